// File: doc/BRIEF.md
# Serial Frame CRC5 Unit

This block produces the 5-bit check code that protects a 24-bit serial frame. The upper 19 bits of the frame are the message, and the lowest 5 bits carry the code. To form the code, the block replaces those 5 low bits with the seed 0b00111. It then divides the resulting 24-bit value by the 6-bit polynomial 0x35. The first step takes the top six bits and reduces them when bit 5 is set. Each of the 18 later steps shifts the low 5 remainder bits up by one, brings in the next frame bit and reduces again. The code is the final 5-bit remainder.

A frame can be presented in two ways. One is as a whole word with a one-cycle start strobe, answered on the next cycle. The other is as a serial stream, most significant bit first, one bit per valid cycle after a stream start strobe, answered on the cycle after the 24th bit.

The same hardware serves the transmit side and the receive side. In generate mode it only reports the code. In check mode it also compares the code with the five received low bits and raises an error flag on a mismatch.

Top module: `crc5_frame_unit`

## Requirements
- R1: On a cycle with `word_start` high while `busy` is low, `done` is high on the next cycle. On that cycle, `crc_out` holds the code of `word_in[23:5]`. The code is computed with the seed 5'b00111 standing in for bits 4:0 and the polynomial 0x35, so the value on `word_in[4:0]` does not change `crc_out`.
- R2: A message of all zeros yields the code 5'h07. `crc_out` changes only on cycles where `done` is high.
- R3: After a cycle with `bit_start` high while idle, `busy` is high from the next cycle. Each later cycle with `bit_valid` high takes `bit_in` as the next frame bit, starting with bit 23. The cycle after the 24th taken bit has `done` high, `busy` low and the same code as R1 for that frame.
- R4: Cycles with `bit_valid` low during a stream do not advance it and do not change the result.
- R5: When `done` is high in check mode (`chk_mode` = 1), `crc_err` is 1 exactly when the computed code differs from received bits 4:0. In generate mode (`chk_mode` = 0), `crc_err` is 0. `crc_err` is 0 whenever `done` is low.
- R6: While `busy` is high, both `bit_start` and `word_start` are ignored. The stream in progress keeps running, and `done` stays low until that stream ends.
- R7: If `word_start` and `bit_start` are high together while idle, the word is served and no stream starts, so `busy` stays low and later bits produce no `done`.
- R8: After reset, `done`, `busy`, `crc_err` and `crc_out` are all 0.
- R9: For a stream, the mode is taken from `chk_mode` in the `bit_start` cycle. Changes to `chk_mode` during the stream have no effect.
- R10: `bit_valid` while idle is ignored: no `done` appears and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_mode | input | 1 | 1 = check received code, 0 = generate only; sampled at a start |
| word_start | input | 1 | Start strobe for the whole-word path |
| word_in | input | 24 | Whole frame; bits 4:0 are the received code |
| bit_start | input | 1 | Start strobe for the serial path |
| bit_valid | input | 1 | `bit_in` holds the next frame bit |
| bit_in | input | 1 | Serial frame bit, most significant first |
| busy | output | 1 | A serial frame is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| crc_out | output | 5 | Computed code, held until the next result |
| crc_err | output | 1 | Mismatch flag in check mode, valid with `done` |

## Verification
The properties assume that the two start strobes and `bit_valid` are synchronous and known after reset, and that a serial frame supplies its bits only after the start cycle. The stimulus changes every input on the falling edge, keeps `bit_valid` low in start cycles and creates gaps and stray strobes on purpose only where a requirement describes them. Expected codes come from a behavioural model of the seed-and-divide procedure, and received codes are formed from that model, either intact or with one bit flipped.

// File: rtl/crc5_pkg.sv
// Shared widths, defaults and the single division step of the frame CRC.
// Assumes the polynomial has its top bit set, so one step clears bit CRC_W.
package crc5_pkg;
    localparam int CRC_W   = 5;
    localparam int FRAME_W = 24;
    localparam logic [CRC_W:0]   POLY_DEF = 6'h35;
    localparam logic [CRC_W-1:0] SEED_DEF = 5'h07;

    // One long-division step: append a bit, reduce when the top bit is set.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] rem,
                                                  input logic             bit_in,
                                                  input logic [CRC_W:0]   poly);
        logic [CRC_W:0] t;
        t = {rem, bit_in};
        if (t[CRC_W]) t = t ^ poly;
        return t[CRC_W-1:0];
    endfunction
endpackage

// File: rtl/crc5_word_calc.sv
// Combinational code of a whole frame: the message bits followed by the seed
// are pushed through FRAME_W unrolled division steps starting from zero.
// Assumes FRAME_W > CRC_W. Also passes out the received low bits.
module crc5_word_calc
    import crc5_pkg::*;
#(
    parameter logic [CRC_W:0]   POLY = POLY_DEF,
    parameter logic [CRC_W-1:0] SEED = SEED_DEF
) (
    input  logic [FRAME_W-1:0] frame_i,
    output logic [CRC_W-1:0]   crc_o,
    output logic [CRC_W-1:0]   rx_o
);
    localparam int MSG_W = FRAME_W - CRC_W;

    logic [FRAME_W-1:0] seeded;
    logic [CRC_W-1:0]   rem [0:FRAME_W];

    // Replace the received code with the seed before division.
    assign seeded = {frame_i[FRAME_W-1:CRC_W], SEED};
    assign rem[0] = '0;

    genvar g;
    generate
        for (g = 0; g < FRAME_W; g++) begin : g_step
            // Step g consumes frame bit FRAME_W-1-g.
            assign rem[g+1] = crc_step(rem[g], seeded[FRAME_W-1-g], POLY);
        end
    endgenerate

    assign crc_o = rem[FRAME_W];
    assign rx_o  = frame_i[CRC_W-1:0];

    logic unused_msg_w;
    assign unused_msg_w = (MSG_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/crc5_bit_engine.sv
// Bit-serial division engine. After go_i it takes one frame bit per valid
// cycle, most significant first. The first MSG_W bits are divided; for the
// last CRC_W bits the seed is divided instead and the stream bits are
// collected as the received code. Assumes go_i is only given while idle.
module crc5_bit_engine
    import crc5_pkg::*;
#(
    parameter logic [CRC_W:0]   POLY = POLY_DEF,
    parameter logic [CRC_W-1:0] SEED = SEED_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             mode_i,
    input  logic             valid_i,
    input  logic             bit_i,
    output logic             busy_o,
    output logic             last_o,
    output logic             mode_o,
    output logic [CRC_W-1:0] crc_o,
    output logic [CRC_W-1:0] rx_o
);
    localparam int MSG_W = FRAME_W - CRC_W;
    localparam int CNT_W = $clog2(FRAME_W);

    logic             busy_q;
    logic             mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rx_q;
    logic [CRC_W-1:0] seed_q;

    logic             take;
    logic             in_msg;
    logic             feed;
    logic [CRC_W-1:0] rem_nxt;
    logic [CRC_W-1:0] rx_nxt;

    // Decode the current bit and form the next remainder.
    always_comb begin
        take    = busy_q & valid_i;
        in_msg  = cnt_q < CNT_W'(MSG_W);
        feed    = in_msg ? bit_i : seed_q[CRC_W-1];
        rem_nxt = crc_step(rem_q, feed, POLY);
        rx_nxt  = {rx_q[CRC_W-2:0], bit_i};
    end

    // Sequence the frame: load on go, advance on each taken bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mode_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            rx_q   <= '0;
            seed_q <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            mode_q <= mode_i;
            cnt_q  <= '0;
            rem_q  <= '0;
            rx_q   <= '0;
            seed_q <= SEED;
        end else if (take) begin
            rem_q <= rem_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (!in_msg) begin
                rx_q   <= rx_nxt;
                seed_q <= {seed_q[CRC_W-2:0], 1'b0};
            end
            if (cnt_q == CNT_W'(FRAME_W - 1)) busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign last_o = take & (cnt_q == CNT_W'(FRAME_W - 1));
    assign mode_o = mode_q;
    assign crc_o  = rem_nxt;
    assign rx_o   = rx_nxt;
endmodule

// File: rtl/crc5_frame_unit.sv
// Frame CRC5 unit: whole-word path answered in one cycle, serial path answered
// the cycle after its last bit. Arbitrates the two starts (word first, none
// while a stream runs) and registers code, done pulse and mismatch flag.
module crc5_frame_unit
    import crc5_pkg::*;
#(
    parameter logic [CRC_W:0]   POLY = POLY_DEF,
    parameter logic [CRC_W-1:0] SEED = SEED_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_mode,
    input  logic               word_start,
    input  logic [FRAME_W-1:0] word_in,
    input  logic               bit_start,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic               busy,
    output logic               done,
    output logic [CRC_W-1:0]   crc_out,
    output logic               crc_err
);
    logic             eng_busy;
    logic             eng_last;
    logic             eng_mode;
    logic [CRC_W-1:0] eng_crc;
    logic [CRC_W-1:0] eng_rx;
    logic [CRC_W-1:0] w_crc;
    logic [CRC_W-1:0] w_rx;
    logic             word_go;
    logic             stream_go;

    // Start arbitration: nothing starts while busy; the word wins a tie.
    assign word_go   = word_start & ~eng_busy;
    assign stream_go = bit_start & ~eng_busy & ~word_start;

    crc5_word_calc #(.POLY(POLY), .SEED(SEED)) word_i (
        .frame_i (word_in),
        .crc_o   (w_crc),
        .rx_o    (w_rx)
    );

    crc5_bit_engine #(.POLY(POLY), .SEED(SEED)) engine_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (stream_go),
        .mode_i  (chk_mode),
        .valid_i (bit_valid),
        .bit_i   (bit_in),
        .busy_o  (eng_busy),
        .last_o  (eng_last),
        .mode_o  (eng_mode),
        .crc_o   (eng_crc),
        .rx_o    (eng_rx)
    );

    logic             done_q;
    logic             err_q;
    logic [CRC_W-1:0] crc_q;

    // Result register: capture whichever path finishes this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            crc_q  <= '0;
        end else begin
            done_q <= word_go | eng_last;
            if (word_go) begin
                crc_q <= w_crc;
                err_q <= chk_mode & (w_crc != w_rx);
            end else if (eng_last) begin
                crc_q <= eng_crc;
                err_q <= eng_mode & (eng_crc != eng_rx);
            end else begin
                err_q <= 1'b0;
            end
        end
    end

    assign busy    = eng_busy;
    assign done    = done_q;
    assign crc_out = crc_q;
    assign crc_err = err_q;
endmodule

// File: rtl/crc5_frame_unit_chk.sv
// Protocol checker for crc5_frame_unit, attached by bind. Assumes inputs are
// synchronous to clk and known once reset is released.
module crc5_frame_unit_chk
    import crc5_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             word_start,
    input logic             bit_start,
    input logic             bit_valid,
    input logic             busy,
    input logic             done,
    input logic [CRC_W-1:0] crc_out,
    input logic             crc_err
);
    // R1: an accepted word answers on the next cycle.
    a_r1_word_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !busy) |=> done);

    // R2: the code only moves on result cycles.
    a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(crc_out));

    // R3: a result never coexists with a running stream.
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: the mismatch flag only appears with a result.
    a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> done);

    // R6: a busy cycle without a bit cannot finish anything, word start or not.
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_valid) |=> !done);

    // R6: a second stream start without a bit leaves the stream running.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_start && !bit_valid) |=> busy);

    // R7: a tied start serves the word and opens no stream.
    a_r7_word_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && bit_start && !busy) |=> !busy);
endmodule

bind crc5_frame_unit crc5_frame_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_start (word_start),
    .bit_start  (bit_start),
    .bit_valid  (bit_valid),
    .busy       (busy),
    .done       (done),
    .crc_out    (crc_out),
    .crc_err    (crc_err)
);

// File: tb/crc5_frame_unit_tb_top.sv
module crc5_frame_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_mode = 1'b0;
    logic        word_start = 1'b0;
    logic [23:0] word_in = '0;
    logic        bit_start = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        busy;
    logic        done;
    logic [4:0]  crc_out;
    logic        crc_err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    crc5_frame_unit dut_i (
        .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode),
        .word_start(word_start), .word_in(word_in),
        .bit_start(bit_start), .bit_valid(bit_valid), .bit_in(bit_in),
        .busy(busy), .done(done), .crc_out(crc_out), .crc_err(crc_err)
    );

    // Behavioural model: seed the low bits, first 6-bit reduction, 18 more steps.
    function automatic logic [4:0] ref_crc(input logic [23:0] f);
        logic [23:0] d;
        logic [5:0]  s;
        logic [5:0]  t;
        d = {f[23:5], 5'b00111};
        t = d[23:18];
        s = t[5] ? (t ^ 6'h35) : t;
        for (int i = 0; i < 18; i++) begin
            t = {s[4:0], d[17-i]};
            s = t[5] ? (t ^ 6'h35) : t;
        end
        return s[4:0];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Word path: strobe one cycle, sample the result on the following low phase.
    task automatic run_word(input logic [23:0] f, input logic mode, input string req,
                            input logic exp_err);
        @(negedge clk);
        word_in = f; chk_mode = mode; word_start = 1'b1;
        @(negedge clk);
        word_start = 1'b0;
        check(done === 1'b1, req, int'(done), 1);
        check(crc_out === ref_crc(f), req, int'(crc_out), int'(ref_crc(f)));
        check(crc_err === exp_err, req, int'(crc_err), int'(exp_err));
    endtask

    // Stream path: start, then 24 bits, optional gap after every third bit.
    task automatic run_stream(input logic [23:0] f, input logic mode, input logic gaps,
                              input logic flip_mode, input string req, input logic exp_err);
        @(negedge clk);
        chk_mode = mode; bit_start = 1'b1;
        @(negedge clk);
        bit_start = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            bit_valid = 1'b1; bit_in = f[i];
            @(negedge clk);
            bit_valid = 1'b0;
            if (flip_mode && i == 12) chk_mode = ~mode;
            if (gaps && (i % 3 == 0) && i != 0) begin
                @(negedge clk);
                @(negedge clk);
            end
        end
        check(done === 1'b1, req, int'(done), 1);
        check(busy === 1'b0, req, int'(busy), 0);
        check(crc_out === ref_crc(f), req, int'(crc_out), int'(ref_crc(f)));
        check(crc_err === exp_err, req, int'(crc_err), int'(exp_err));
    endtask

    // {stream path, check mode, corrupt received code, 19-bit message}
    localparam logic [21:0] VECS [0:8] = '{
        {1'b0, 1'b0, 1'b0, 19'h00000},
        {1'b0, 1'b0, 1'b0, 19'h7FFFF},
        {1'b0, 1'b1, 1'b0, 19'h12345},
        {1'b0, 1'b1, 1'b1, 19'h2AAAA},
        {1'b1, 1'b0, 1'b0, 19'h55555},
        {1'b1, 1'b1, 1'b0, 19'h40001},
        {1'b1, 1'b1, 1'b1, 19'h3C3C3},
        {1'b0, 1'b0, 1'b0, 19'h00001},
        {1'b1, 1'b0, 1'b0, 19'h7FFFF}
    };

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] f;
        logic [4:0]  c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check(done === 1'b0 && busy === 1'b0, "R8", int'({done, busy}), 0);
        check(crc_out === 5'h00 && crc_err === 1'b0, "R8", int'({crc_err, crc_out}), 0);

        // Vector table: R1 word path, R3 stream path, R5 generate/check
        for (int v = 0; v < 9; v++) begin
            c = ref_crc({VECS[v][18:0], 5'h00});
            if (VECS[v][20]) f = {VECS[v][18:0], VECS[v][19] ? (c ^ 5'h01) : c};
            else             f = {VECS[v][18:0], 5'h0A};
            if (VECS[v][21]) run_stream(f, VECS[v][20], 1'b0, 1'b0, "R3/R5", VECS[v][20] & VECS[v][19]);
            else             run_word(f, VECS[v][20], "R1/R5", VECS[v][20] & VECS[v][19]);
        end

        // R2: zero message gives the seed; code held while done low
        run_word(24'h00001F, 1'b0, "R2", 1'b0);
        check(crc_out === 5'h07, "R2", int'(crc_out), 7);
        @(negedge clk);
        check(done === 1'b0 && crc_out === 5'h07, "R2", int'(crc_out), 7);

        // R4: gaps in the stream
        f = {19'h1B2C3, 5'h00};
        run_stream(f, 1'b0, 1'b1, 1'b0, "R4", 1'b0);

        // R9: mode flips mid-stream; received code is wrong so check mode must hold
        c = ref_crc(24'h0ABCD0);
        run_stream({19'h055E6, c ^ 5'h10}, 1'b1, 1'b0, 1'b1, "R9", 1'b1);
        run_stream({19'h055E6, c ^ 5'h10}, 1'b0, 1'b0, 1'b1, "R9", 1'b0);

        // R6: starts while busy are ignored
        f = {19'h6D5A3, 5'h00};
        @(negedge clk);
        chk_mode = 1'b0; bit_start = 1'b1;
        @(negedge clk);
        bit_start = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            bit_valid = 1'b1; bit_in = f[i];
            @(negedge clk);
            bit_valid = 1'b0;
            if (i == 10) begin
                bit_start = 1'b1; word_start = 1'b1; word_in = 24'hFFFFFF;
                @(negedge clk);
                bit_start = 1'b0; word_start = 1'b0;
                check(done === 1'b0 && busy === 1'b1, "R6", int'({done, busy}), 1);
            end
        end
        check(done === 1'b1, "R6", int'(done), 1);
        check(crc_out === ref_crc(f), "R6", int'(crc_out), int'(ref_crc(f)));

        // R7: tied starts serve the word only
        @(negedge clk);
        word_in = 24'h123456; chk_mode = 1'b0; word_start = 1'b1; bit_start = 1'b1;
        @(negedge clk);
        word_start = 1'b0; bit_start = 1'b0;
        check(done === 1'b1 && crc_out === ref_crc(24'h123456), "R7", int'(crc_out), int'(ref_crc(24'h123456)));
        check(busy === 1'b0, "R7", int'(busy), 0);
        for (int i = 0; i < 24; i++) begin
            bit_valid = 1'b1; bit_in = i[0];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R7", int'({done, busy}), 0);

        // R10: valid bits while idle are ignored
        for (int i = 0; i < 30; i++) begin
            bit_valid = 1'b1; bit_in = 1'b1;
            @(negedge clk);
            if (done !== 1'b0 || busy !== 1'b0) check(1'b0, "R10", int'({done, busy}), 0);
        end
        bit_valid = 1'b0;
        check(done === 1'b0 && busy === 1'b0, "R10", int'({done, busy}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule